// File: doc/BRIEF.md
# Alternating-Polarity Ripple Adder-Subtractor

A parameterised, purely combinational two's-complement adder-subtractor made of a row of identical full-adder slices. Each slice forms its complemented carry first and derives its sum from that complemented carry, so the carry leaving a slice is naturally inverted. Instead of re-inverting it, the next slice works entirely in complemented polarity: its operand bits and incoming carry are complements, and by self-duality of the majority function its outgoing carry comes back in true polarity. Slices therefore alternate between true and complemented polarity, and no inverter sits on the ripple path.

A single control input picks addition or subtraction. For subtraction every bit of the second operand is complemented and the carry into bit 0 is forced high, giving a + ~b + 1 on the same chain. Sums from complemented slices are re-inverted off the critical path. The final carry is always presented in true polarity whether the width is odd or even, and a signed-overflow flag is taken from the carries into and out of the top slice.

Top module: `alt_ripple_addsub`

## Requirements
- R1: With sub_i = 0, sum_o equals (a_i + b_i) mod 2^N.
- R2: With sub_i = 1, sum_o equals (a_i - b_i) mod 2^N, computed as a_i + ~b_i + 1.
- R3: With sub_i = 0, carry_o equals bit N of the unsigned (N+1)-bit sum a_i + b_i.
- R4: With sub_i = 1, carry_o is the carry out of a_i + ~b_i + 1, which is 1 exactly when a_i >= b_i as unsigned numbers.
- R5: With sub_i = 0, ovf_o is 1 exactly when a_i and b_i have the same sign bit (bit N-1) and sum_o's sign bit differs from it.
- R6: With sub_i = 1, ovf_o is 1 exactly when a_i and b_i differ in sign bit and sum_o's sign bit differs from that of a_i.
- R7: For an odd width, where the last slice works in true polarity and emits a complemented carry, carry_o is still presented in true polarity and obeys R3 and R4.
- R8: A carry that ripples through every slice is delivered: all-ones plus one gives sum_o = 0 with carry_o = 1, and zero minus one gives all-ones with carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sub_i | input | 1 | 0 selects a+b, 1 selects a-b |
| sum_o | output | N | Sum or difference, modulo 2^N |
| carry_o | output | 1 | Carry out of the top slice, true polarity |
| ovf_o | output | 1 | Two's-complement overflow |

## Verification
Widths 4 and 5 are swept exhaustively over both operands and both operations, so every carry pattern through a chain ending on a complemented slice (even width) and on a true slice (odd width) is seen; a polarity slip at any node shows as a wrong sum bit or a wrong final carry. Widths 8 and 16 take random vectors plus zero, all-ones, single-bit and sign-boundary operands, which separate a correct subtract carry-in from one left at 0, and correct overflow from a flag built on the wrong carry. The full-ripple corners isolate the longest carry path from bit 0 to the output.

// File: rtl/alt_ripple_pkg.sv
package alt_ripple_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  // Carry node k feeds slice k; odd nodes travel complemented.
  function automatic bit node_inv(int unsigned k);
    return (k % 2) == 1;
  endfunction
endpackage

// File: rtl/alt_ripple_slice.sv
module alt_ripple_slice (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic cp_o
);
  logic cp;
  assign cp   = ~((x_i & y_i) | (c_i & (x_i | y_i)));
  // 1 or 3 inputs high: all three, or none of the carry pairs with at least one
  assign s_o  = (x_i & y_i & c_i) | (cp & (x_i | y_i | c_i));
  assign cp_o = cp;
endmodule

// File: rtl/alt_ripple_prep.sv
module alt_ripple_prep #(
  parameter int unsigned N = alt_ripple_pkg::DEF_WIDTH
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] x_o,
  output logic [N-1:0] y_o,
  output logic         c0_o
);
  logic [N-1:0] b_cond;
  assign b_cond = b_i ^ {N{sub_i}};
  assign c0_o   = sub_i;  // node 0 is true polarity

  for (genvar k = 0; k < N; k++) begin : g_pol
    if (alt_ripple_pkg::node_inv(k)) begin : g_neg
      assign x_o[k] = ~a_i[k];
      assign y_o[k] = ~b_cond[k];
    end else begin : g_pos
      assign x_o[k] = a_i[k];
      assign y_o[k] = b_cond[k];
    end
  end
endmodule

// File: rtl/alt_ripple_chain.sv
module alt_ripple_chain #(
  parameter int unsigned N = alt_ripple_pkg::DEF_WIDTH
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         c0_i,
  output logic [N-1:0] s_raw_o,
  output logic         c_top_in_o,
  output logic         c_top_out_o
);
  logic [N:0] node;
  assign node[0] = c0_i;

  for (genvar k = 0; k < N; k++) begin : g_slice
    alt_ripple_slice u_slice (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (node[k]),
      .s_o (s_raw_o[k]),
      .cp_o(node[k+1])
    );
  end

  assign c_top_in_o  = node[N-1];
  assign c_top_out_o = node[N];
endmodule

// File: rtl/alt_ripple_fix.sv
module alt_ripple_fix #(
  parameter int unsigned N = alt_ripple_pkg::DEF_WIDTH
) (
  input  logic [N-1:0] s_raw_i,
  input  logic         c_top_in_i,
  input  logic         c_top_out_i,
  output logic [N-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic c_in_true;

  for (genvar k = 0; k < N; k++) begin : g_sum
    if (alt_ripple_pkg::node_inv(k)) begin : g_neg
      assign sum_o[k] = ~s_raw_i[k];
    end else begin : g_pos
      assign sum_o[k] = s_raw_i[k];
    end
  end

  if (alt_ripple_pkg::node_inv(N)) begin : g_cout_neg
    assign carry_o = ~c_top_out_i;
  end else begin : g_cout_pos
    assign carry_o = c_top_out_i;
  end

  if (alt_ripple_pkg::node_inv(N-1)) begin : g_cin_neg
    assign c_in_true = ~c_top_in_i;
  end else begin : g_cin_pos
    assign c_in_true = c_top_in_i;
  end

  assign ovf_o = c_in_true ^ carry_o;
endmodule

// File: rtl/alt_ripple_addsub.sv
module alt_ripple_addsub #(
  parameter int unsigned N = alt_ripple_pkg::DEF_WIDTH
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [N-1:0] x, y, s_raw;
  logic         c0, c_top_in, c_top_out;

  alt_ripple_prep #(.N(N)) u_prep (
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(sub_i),
    .x_o  (x),
    .y_o  (y),
    .c0_o (c0)
  );

  alt_ripple_chain #(.N(N)) u_chain (
    .x_i        (x),
    .y_i        (y),
    .c0_i       (c0),
    .s_raw_o    (s_raw),
    .c_top_in_o (c_top_in),
    .c_top_out_o(c_top_out)
  );

  alt_ripple_fix #(.N(N)) u_fix (
    .s_raw_i    (s_raw),
    .c_top_in_i (c_top_in),
    .c_top_out_i(c_top_out),
    .sum_o      (sum_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: rtl/alt_ripple_addsub_chk.sv
module alt_ripple_addsub_chk #(
  parameter int unsigned N = alt_ripple_pkg::DEF_WIDTH
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         sub_i,
  input logic [N-1:0] sum_o,
  input logic         carry_o,
  input logic         ovf_o
);
  logic [N:0] add_ref, sub_ref;
  logic       ovf_add_ref, ovf_sub_ref;

  always_comb begin
    add_ref     = {1'b0, a_i} + {1'b0, b_i};
    sub_ref     = {1'b0, a_i} + {1'b0, ~b_i} + {{N{1'b0}}, 1'b1};
    ovf_add_ref = (a_i[N-1] == b_i[N-1]) && (sum_o[N-1] != a_i[N-1]);
    ovf_sub_ref = (a_i[N-1] != b_i[N-1]) && (sum_o[N-1] != a_i[N-1]);
    if (!sub_i) begin
      AST_ADD_SUM:   assert (sum_o == add_ref[N-1:0]);   // R1
      AST_ADD_CARRY: assert (carry_o == add_ref[N]);     // R3
      AST_ADD_OVF:   assert (ovf_o == ovf_add_ref);      // R5
    end else begin
      AST_SUB_DIFF:  assert (sum_o == sub_ref[N-1:0]);   // R2
      AST_SUB_CARRY: assert (carry_o == (a_i >= b_i));   // R4
      AST_SUB_OVF:   assert (ovf_o == ovf_sub_ref);      // R6
    end
  end
endmodule

bind alt_ripple_addsub alt_ripple_addsub_chk #(.N(N)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .sub_i  (sub_i),
  .sum_o  (sum_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o)
);

// File: tb/alt_ripple_addsub_test.sv
`timescale 1ns/1ps
module alt_ripple_addsub_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [15:0] a_v = '0, b_v = '0;
  logic        sub_v = 1'b0;

  logic [3:0]  s4;  logic c4, v4;
  logic [4:0]  s5;  logic c5, v5;
  logic [7:0]  s8;  logic c8, v8;
  logic [15:0] s16; logic c16, v16;

  alt_ripple_addsub #(.N(4)) uut_w4 (
    .a_i(a_v[3:0]), .b_i(b_v[3:0]), .sub_i(sub_v),
    .sum_o(s4), .carry_o(c4), .ovf_o(v4));
  alt_ripple_addsub #(.N(5)) uut_w5 (
    .a_i(a_v[4:0]), .b_i(b_v[4:0]), .sub_i(sub_v),
    .sum_o(s5), .carry_o(c5), .ovf_o(v5));
  alt_ripple_addsub #(.N(8)) uut (
    .a_i(a_v[7:0]), .b_i(b_v[7:0]), .sub_i(sub_v),
    .sum_o(s8), .carry_o(c8), .ovf_o(v8));
  alt_ripple_addsub #(.N(16)) uut_w16 (
    .a_i(a_v), .b_i(b_v), .sub_i(sub_v),
    .sum_o(s16), .carry_o(c16), .ovf_o(v16));

  task automatic check(string req, int w, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s w=%0d a=%h b=%h sub=%0d actual=%h expected=%h",
               req, w, a_v, b_v, sub_v, act, exp);
    end
  endtask

  // Arithmetic reference: two's-complement add or subtract at width w.
  task automatic run(int w, logic [15:0] a, logic [15:0] b, logic sub);
    logic [17:0] mask, am, bm, full, es;
    logic        ec, ev, sa, sb, ss;
    logic [15:0] as_;
    logic        ac, av;
    a_v = a; b_v = b; sub_v = sub;
    #2;
    mask = (18'd1 << w) - 18'd1;
    am   = {2'b0, a} & mask;
    bm   = {2'b0, b} & mask;
    full = sub ? (am + (mask - bm) + 18'd1) : (am + bm);
    es   = full & mask;
    ec   = full[w];
    sa   = am[w-1]; sb = bm[w-1]; ss = es[w-1];
    ev   = sub ? ((sa != sb) && (ss != sa)) : ((sa == sb) && (ss != sa));
    case (w)
      4:       begin as_ = {12'b0, s4}; ac = c4;  av = v4;  end
      5:       begin as_ = {11'b0, s5}; ac = c5;  av = v5;  end
      8:       begin as_ = {8'b0, s8};  ac = c8;  av = v8;  end
      default: begin as_ = s16;         ac = c16; av = v16; end
    endcase
    check(sub ? "R2" : "R1", w, {1'b0, as_}, es[16:0]);
    check(w == 5 ? "R7" : (sub ? "R4" : "R3"), w, {16'b0, ac}, {16'b0, ec});
    check(sub ? "R6" : "R5", w, {16'b0, av}, {16'b0, ev});
    #2;
  endtask

  initial begin
    #3;
    // reset-state style check: zero operands, add
    run(8, 16'h0, 16'h0, 1'b0);
    check("R1", 8, {9'b0, s8}, 17'h0);

    // R1..R6 exhaustive at width 4 (even width, complemented last slice)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run(4, 16'(a), 16'(b), s[0]);

    // R7 exhaustive at width 5 (odd width, true-polarity last slice)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          run(5, 16'(a), 16'(b), s[0]);

    // corner operands at 8 and 16 bits
    for (int w = 8; w <= 16; w += 8) begin
      logic [15:0] ones, msb;
      ones = (w == 8) ? 16'h00ff : 16'hffff;
      msb  = (w == 8) ? 16'h0080 : 16'h8000;
      for (int s = 0; s < 2; s++) begin
        run(w, 16'h0, 16'h0, s[0]);
        run(w, ones, ones, s[0]);
        run(w, ones, 16'h0, s[0]);
        run(w, 16'h0, ones, s[0]);
        run(w, msb, msb, s[0]);
        run(w, msb - 16'h1, 16'h1, s[0]);
        run(w, msb, 16'h1, s[0]);
        run(w, 16'h1, msb, s[0]);
      end
      // R8 full ripple from bit 0 to carry out
      run(w, ones, 16'h1, 1'b0);
      check("R8", w, {16'b0, (w == 8) ? c8 : c16}, 17'h1);
      check("R8", w, {1'b0, (w == 8) ? {8'b0, s8} : s16}, 17'h0);
      run(w, 16'h0, 16'h1, 1'b1);
      check("R8", w, {16'b0, (w == 8) ? c8 : c16}, 17'h0);
      check("R8", w, {1'b0, (w == 8) ? {8'b0, s8} : s16}, {1'b0, ones});
    end

    // random vectors at 8 and 16 bits
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      run(8, ra, rb, i[0]);
      run(16, ra, rb, i[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule